// File: doc/BRIEF.md
# Multi-Port RAM with Per-Pair Collision Policies

This block is a single-clock RAM with a parameterized number of synchronous write ports and registered read ports. Each write port has one enable bit for every data bit, so a port can update any subset of a word. Each read port has its own read enable, an asynchronous reset, a synchronous reset and a power-up value. A port-wide synchronous `rst` loads that power-up value into every read register.

Same-cycle conflicts are settled at elaboration time by bitmask parameters, one bit for each port pair. For a read port and a write port that address the same word in the same cycle, the read returns either the word before the write, the word with the written bits already merged in, or an unspecified (all-X) word. For two write ports that update the same bits of one word, a mask says which port wins. Only a higher-numbered port may win over a lower-numbered one. A lower port's bits that the winner does not enable still land.

The block suits register files and shared tables where several agents hit the same array every cycle. It is also useful where the collision behaviour of each port pair has to be stated rather than left to chance.

Top module: `mpram_rdw`

## Requirements
- R1: A write stores `wr_data` only on the bits where its `wr_be` bit is 1. All other bits of the word keep their value. An all-zero `wr_be` is no write.
- R2: When a read port's enable is high and no reset applies, its output after the next rising edge equals the stored word at `rd_addr`, with no write to that address in the same cycle.
- R3: When a read port's enable is low and no reset applies, its output holds its value across the edge, even if writes take place.
- R4: For a read/write pair whose bit in `RD_NEW_MASK` (index read*N_WR+write) is set, a same-cycle same-address read returns the written data on the bits that write actually stores, and the old data on the other bits.
- R5: For a read/write pair with clear bits in both `RD_NEW_MASK` and `RD_UNDEF_MASK`, a same-cycle same-address read returns the word as it was before the write.
- R6: When two writes hit the same word and the `WR_WIN_MASK` bit (index winner*N_WR+loser, winner ID higher) is set, the winner's enabled bits are stored. The loser's enabled bits that the winner does not enable are also stored.
- R7: While a read port's `rd_arst` bit is high, its output equals that port's `RD_ARST_VAL` slice at once, without waiting for a clock edge. This reset overrides every other control.
- R8: For a read port whose `RD_SRST_NEEDS_EN` bit is 1, `rd_srst` loads the `RD_SRST_VAL` slice on the edge only when its read enable is also high. With the enable low, the output holds.
- R9: For a read port whose `RD_SRST_NEEDS_EN` bit is 0, `rd_srst` loads the `RD_SRST_VAL` slice on the edge regardless of the read enable, and it overrides a read.
- R10: While `rst` is high and `rd_arst` is low, each read port loads its `RD_INIT_VAL` slice on the edge. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all ports |
| rst | input | 1 | Synchronous active-high reset; loads read registers with their power-up values |
| wr_addr | input | N_WR*ADDR_W | Write addresses, port w at bits w*ADDR_W upward |
| wr_data | input | N_WR*DATA_W | Write data, port w at bits w*DATA_W upward |
| wr_be | input | N_WR*DATA_W | Per-bit write enables, same packing as wr_data |
| rd_en | input | N_RD | Read enable per read port |
| rd_addr | input | N_RD*ADDR_W | Read addresses, port r at bits r*ADDR_W upward |
| rd_arst | input | N_RD | Asynchronous active-high reset per read port |
| rd_srst | input | N_RD | Synchronous active-high reset per read port |
| rd_data | output | N_RD*DATA_W | Registered read data, port r at bits r*DATA_W upward |

## Verification
The bench builds the block with 8-bit words, 16 entries, two write ports and three read ports. Write port 1 has priority over write port 0. Read port 0 sees both writes early. Read port 1 always sees the old data. Read port 2 sees port 1's writes early and gets undefined data on a collision with port 0. Ports 0 and 2 gate their synchronous reset by the read enable and port 1 does not. This brings the early, old and undefined read outcomes, both reset-gating choices and the write-write priority rule into one build. Random traffic confined to four addresses makes same-word collisions frequent.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

  // Outcome of a read that meets a write on the same word in one cycle
  typedef enum logic [1:0] {
    RDW_OLD   = 2'd0,
    RDW_NEW   = 2'd1,
    RDW_UNDEF = 2'd2
  } rdw_e;

  // Bit position of a (row, col) pair inside a flattened pair mask
  function automatic int pair_bit(input int row, input int col, input int ncol);
    return row * ncol + col;
  endfunction

  function automatic rdw_e rdw_mode(input logic early, input logic undef);
    if (undef) return RDW_UNDEF;
    if (early) return RDW_NEW;
    return RDW_OLD;
  endfunction

endpackage

// File: rtl/mpram_wr_arb.sv
// Resolves write-write collisions into per-port effective bit enables.
module mpram_wr_arb #(
  parameter int N_WR   = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [N_WR*N_WR-1:0] WIN_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_WR*ADDR_W-1:0]   wr_addr,
  input  logic [N_WR*DATA_W-1:0]   wr_be,
  output logic [N_WR*DATA_W-1:0]   eff_be
);

  // A port drops the bits that a port holding priority over it also writes
  always_comb begin
    for (int j = 0; j < N_WR; j++) begin
      eff_be[j*DATA_W +: DATA_W] = wr_be[j*DATA_W +: DATA_W];
      for (int k = 0; k < N_WR; k++) begin
        if (k != j && WIN_MASK[mpram_pkg::pair_bit(k, j, N_WR)] &&
            wr_addr[k*ADDR_W +: ADDR_W] == wr_addr[j*ADDR_W +: ADDR_W])
          eff_be[j*DATA_W +: DATA_W] = eff_be[j*DATA_W +: DATA_W] & ~wr_be[k*DATA_W +: DATA_W];
      end
    end
  end

  // Overlapping writes between ports with no priority rule are a usage error
  for (genvar i = 0; i < N_WR; i++) begin : g_lo
    for (genvar j = i + 1; j < N_WR; j++) begin : g_hi
      if (!WIN_MASK[j*N_WR+i]) begin : g_unres
        AST_WR_UNRESOLVED: assert property (@(posedge clk) disable iff (rst)
          (wr_addr[i*ADDR_W +: ADDR_W] == wr_addr[j*ADDR_W +: ADDR_W]) |->
          ((wr_be[i*DATA_W +: DATA_W] & wr_be[j*DATA_W +: DATA_W]) == '0)); // R6
      end
    end
  end

endmodule

// File: rtl/mpram_store.sv
// Storage array; colliding writes to one word merge into one word value.
module mpram_store #(
  parameter int N_WR   = 2,
  parameter int N_RD   = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_WR*ADDR_W-1:0]   wr_addr,
  input  logic [N_WR*DATA_W-1:0]   wr_data,
  input  logic [N_WR*DATA_W-1:0]   eff_be,
  input  logic [N_RD*ADDR_W-1:0]   rd_addr,
  output logic [N_RD*DATA_W-1:0]   rd_old
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] merged [N_WR];

  // Every port aimed at a word computes the same merged result for it
  always_comb begin
    for (int j = 0; j < N_WR; j++) begin
      merged[j] = mem[wr_addr[j*ADDR_W +: ADDR_W]];
      for (int k = 0; k < N_WR; k++) begin
        if (wr_addr[k*ADDR_W +: ADDR_W] == wr_addr[j*ADDR_W +: ADDR_W])
          merged[j] = (merged[j] & ~eff_be[k*DATA_W +: DATA_W]) |
                      (wr_data[k*DATA_W +: DATA_W] & eff_be[k*DATA_W +: DATA_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < N_WR; j++) begin
      if (|eff_be[j*DATA_W +: DATA_W])
        mem[wr_addr[j*ADDR_W +: ADDR_W]] <= merged[j];
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_old[r*DATA_W +: DATA_W] = mem[rd_addr[r*ADDR_W +: ADDR_W]];
  end

  for (genvar j = 0; j < N_WR; j++) begin : g_chk
    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
      (|eff_be[j*DATA_W +: DATA_W]) |=>
      ((mem[$past(wr_addr[j*ADDR_W +: ADDR_W])] & $past(eff_be[j*DATA_W +: DATA_W])) ==
       ($past(wr_data[j*DATA_W +: DATA_W]) & $past(eff_be[j*DATA_W +: DATA_W])))); // R1
  end

endmodule

// File: rtl/mpram_rd_port.sv
// One registered read port with collision bypass and its own resets.
module mpram_rd_port #(
  parameter int N_WR   = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [N_WR-1:0]   NEW_ROW   = '0,
  parameter logic [N_WR-1:0]   UNDEF_ROW = '0,
  parameter bit                SRST_NEEDS_EN = 1'b0,
  parameter logic [DATA_W-1:0] INIT_VAL  = '0,
  parameter logic [DATA_W-1:0] ARST_VAL  = '0,
  parameter logic [DATA_W-1:0] SRST_VAL  = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   arst,
  input  logic                   srst,
  input  logic                   en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      old_word,
  input  logic [N_WR*ADDR_W-1:0] wr_addr,
  input  logic [N_WR*DATA_W-1:0] wr_data,
  input  logic [N_WR*DATA_W-1:0] eff_be,
  output logic [DATA_W-1:0]      q
);

  logic [N_WR-1:0]   hit;
  logic [DATA_W-1:0] nxt;
  logic              undef;
  logic              srst_take;

  always_comb begin
    for (int w = 0; w < N_WR; w++)
      hit[w] = (|eff_be[w*DATA_W +: DATA_W]) && (wr_addr[w*ADDR_W +: ADDR_W] == addr);
  end

  always_comb begin
    nxt   = old_word;
    undef = 1'b0;
    for (int w = 0; w < N_WR; w++) begin
      if (hit[w]) begin
        if (UNDEF_ROW[w])
          undef = 1'b1;
        else if (NEW_ROW[w])
          nxt = (nxt & ~eff_be[w*DATA_W +: DATA_W]) |
                (wr_data[w*DATA_W +: DATA_W] & eff_be[w*DATA_W +: DATA_W]);
      end
    end
    if (undef) nxt = 'x;
  end

  assign srst_take = srst && (en || !SRST_NEEDS_EN);

  always_ff @(posedge clk or posedge arst) begin
    if (arst)           q <= ARST_VAL;
    else if (rst)       q <= INIT_VAL;
    else if (srst_take) q <= SRST_VAL;
    else if (en)        q <= nxt;
  end

  AST_RD_ARST: assert property (@(posedge clk) disable iff (rst)
    arst |-> (q == ARST_VAL)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !srst && !arst) |=> (arst || $stable(q))); // R3
  AST_RD_SRST: assert property (@(posedge clk) disable iff (rst)
    (srst && !arst && (en || !SRST_NEEDS_EN)) |=> (arst || q == SRST_VAL)); // R8
  AST_RD_INIT: assert property (@(posedge clk) disable iff (arst)
    rst |=> (q == INIT_VAL)); // R10

  for (genvar w = 0; w < N_WR; w++) begin : g_pair
    localparam mpram_pkg::rdw_e MODE = mpram_pkg::rdw_mode(NEW_ROW[w], UNDEF_ROW[w]);
    if (MODE == mpram_pkg::RDW_NEW) begin : g_new
      AST_RD_EARLY: assert property (@(posedge clk) disable iff (rst)
        (en && !srst && !arst && hit[w] && $countones(hit) == 1 &&
         (&eff_be[w*DATA_W +: DATA_W])) |=>
        (arst || q == $past(wr_data[w*DATA_W +: DATA_W]))); // R4
    end else if (MODE == mpram_pkg::RDW_OLD) begin : g_old
      AST_RD_OLD: assert property (@(posedge clk) disable iff (rst)
        (en && !srst && !arst && hit[w] && $countones(hit) == 1) |=>
        (arst || q == $past(old_word))); // R5
    end
  end

endmodule

// File: rtl/mpram_rdw.sv
// Multi-port RAM top: write arbitration, storage, and N_RD read ports.
module mpram_rdw #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int N_WR   = 2,
  parameter int N_RD   = 3,
  parameter logic [N_RD*N_WR-1:0] RD_NEW_MASK   = 6'b100011,
  parameter logic [N_RD*N_WR-1:0] RD_UNDEF_MASK = 6'b010000,
  parameter logic [N_WR*N_WR-1:0] WR_WIN_MASK   = 4'b0100,
  parameter logic [N_RD-1:0]      RD_SRST_NEEDS_EN = 3'b101,
  parameter logic [N_RD*DATA_W-1:0] RD_INIT_VAL = 24'h33_22_11,
  parameter logic [N_RD*DATA_W-1:0] RD_ARST_VAL = 24'hC3_B2_A1,
  parameter logic [N_RD*DATA_W-1:0] RD_SRST_VAL = 24'h5E_4D_3C
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_WR*$clog2(DEPTH)-1:0]     wr_addr,
  input  logic [N_WR*DATA_W-1:0]            wr_data,
  input  logic [N_WR*DATA_W-1:0]            wr_be,
  input  logic [N_RD-1:0]                   rd_en,
  input  logic [N_RD*$clog2(DEPTH)-1:0]     rd_addr,
  input  logic [N_RD-1:0]                   rd_arst,
  input  logic [N_RD-1:0]                   rd_srst,
  output logic [N_RD*DATA_W-1:0]            rd_data
);

  localparam int ADDR_W = $clog2(DEPTH);

  logic [N_WR*DATA_W-1:0] eff_be;
  logic [N_RD*DATA_W-1:0] rd_old;

  mpram_wr_arb #(
    .N_WR(N_WR), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_MASK(WR_WIN_MASK)
  ) u_arb (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_be(wr_be), .eff_be(eff_be)
  );

  mpram_store #(
    .N_WR(N_WR), .N_RD(N_RD), .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .eff_be(eff_be),
    .rd_addr(rd_addr), .rd_old(rd_old)
  );

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    mpram_rd_port #(
      .N_WR(N_WR), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .NEW_ROW(RD_NEW_MASK[r*N_WR +: N_WR]),
      .UNDEF_ROW(RD_UNDEF_MASK[r*N_WR +: N_WR]),
      .SRST_NEEDS_EN(RD_SRST_NEEDS_EN[r]),
      .INIT_VAL(RD_INIT_VAL[r*DATA_W +: DATA_W]),
      .ARST_VAL(RD_ARST_VAL[r*DATA_W +: DATA_W]),
      .SRST_VAL(RD_SRST_VAL[r*DATA_W +: DATA_W])
    ) u_port (
      .clk(clk), .rst(rst), .arst(rd_arst[r]), .srst(rd_srst[r]), .en(rd_en[r]),
      .addr(rd_addr[r*ADDR_W +: ADDR_W]),
      .old_word(rd_old[r*DATA_W +: DATA_W]),
      .wr_addr(wr_addr), .wr_data(wr_data), .eff_be(eff_be),
      .q(rd_data[r*DATA_W +: DATA_W])
    );
  end

endmodule

// File: tb/mpram_rdw_tb_top.sv
module mpram_rdw_tb_top;

  localparam int W  = 8;
  localparam int D  = 16;
  localparam int NW = 2;
  localparam int NR = 3;
  localparam int AW = 4;
  localparam logic [NR*NW-1:0] T_NEW   = 6'b100011;
  localparam logic [NR*NW-1:0] T_UNDEF = 6'b010000;
  localparam logic [NW*NW-1:0] T_WIN   = 4'b0100;
  localparam logic [NR-1:0]    T_GATE  = 3'b101;
  localparam logic [NR*W-1:0]  T_INIT  = 24'h33_22_11;
  localparam logic [NR*W-1:0]  T_ARST  = 24'hC3_B2_A1;
  localparam logic [NR*W-1:0]  T_SRST  = 24'h5E_4D_3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*W-1:0]  wr_data = '0;
  logic [NW*W-1:0]  wr_be   = '0;
  logic [NR-1:0]    rd_en   = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR-1:0]    rd_arst = '0;
  logic [NR-1:0]    rd_srst = '0;
  logic [NR*W-1:0]  rd_data;

  always #2 clk = ~clk;

  mpram_rdw #(
    .DATA_W(W), .DEPTH(D), .N_WR(NW), .N_RD(NR),
    .RD_NEW_MASK(T_NEW), .RD_UNDEF_MASK(T_UNDEF), .WR_WIN_MASK(T_WIN),
    .RD_SRST_NEEDS_EN(T_GATE), .RD_INIT_VAL(T_INIT), .RD_ARST_VAL(T_ARST),
    .RD_SRST_VAL(T_SRST)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_arst(rd_arst), .rd_srst(rd_srst),
    .rd_data(rd_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] ref_mem [D];
  logic [W-1:0] exp_q   [NR];
  bit           exp_ok  [NR];
  string        exp_tag [NR];

  function automatic logic [W-1:0] port_q(input int r);
    return rd_data[r*W +: W];
  endfunction

  task automatic check(input string tag, input int r, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s read port %0d: got %h expected %h", tag, r, got, exp);
    end
  endtask

  task automatic idle();
    wr_be   = '0;
    rd_en   = '0;
    rd_srst = '0;
    rd_arst = '0;
  endtask

  task automatic set_wr(input int j, input int a, input logic [W-1:0] d,
                        input logic [W-1:0] be);
    wr_addr[j*AW +: AW] = AW'(a);
    wr_data[j*W +: W]   = d;
    wr_be[j*W +: W]     = be;
  endtask

  task automatic set_rd(input int r, input bit en, input int a);
    rd_en[r]            = en;
    rd_addr[r*AW +: AW] = AW'(a);
  endtask

  // Predict every read port after the next edge, update the model, then compare
  task automatic step();
    logic [W-1:0] eff [NW];
    for (int j = 0; j < NW; j++) begin
      eff[j] = wr_be[j*W +: W];
      for (int k = 0; k < NW; k++)
        if (k != j && T_WIN[k*NW+j] && wr_addr[k*AW +: AW] == wr_addr[j*AW +: AW])
          eff[j] = eff[j] & ~wr_be[k*W +: W];
    end
    for (int r = 0; r < NR; r++) begin
      logic [AW-1:0] ra;
      ra = rd_addr[r*AW +: AW];
      if (rd_arst[r]) begin
        exp_q[r] = T_ARST[r*W +: W]; exp_ok[r] = 1'b1; exp_tag[r] = "R7";
      end else if (rst) begin
        exp_q[r] = T_INIT[r*W +: W]; exp_ok[r] = 1'b1; exp_tag[r] = "R10";
      end else if (rd_srst[r] && (rd_en[r] || !T_GATE[r])) begin
        exp_q[r] = T_SRST[r*W +: W]; exp_ok[r] = 1'b1;
        exp_tag[r] = T_GATE[r] ? "R8" : "R9";
      end else if (rd_en[r]) begin
        logic [W-1:0] v;
        bit und;
        v = ref_mem[ra]; und = 1'b0; exp_tag[r] = "R2";
        for (int w = 0; w < NW; w++) begin
          if (|eff[w] && wr_addr[w*AW +: AW] == ra) begin
            if (T_UNDEF[r*NW+w]) und = 1'b1;
            else if (T_NEW[r*NW+w]) begin
              v = (v & ~eff[w]) | (wr_data[w*W +: W] & eff[w]);
              exp_tag[r] = "R4";
            end else if (exp_tag[r] != "R4") exp_tag[r] = "R5";
          end
        end
        exp_q[r] = v; exp_ok[r] = !und;
      end else begin
        exp_tag[r] = rd_srst[r] ? "R8" : "R3";
      end
    end
    for (int j = 0; j < NW; j++)
      if (|eff[j])
        ref_mem[wr_addr[j*AW +: AW]] = (ref_mem[wr_addr[j*AW +: AW]] & ~eff[j]) |
                                       (wr_data[j*W +: W] & eff[j]);
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < NR; r++)
      if (exp_ok[r]) check(exp_tag[r], r, port_q(r), exp_q[r]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    for (int r = 0; r < NR; r++) exp_ok[r] = 1'b0;
    for (int a = 0; a < D; a++) ref_mem[a] = 'x;

    // R10: reset state
    idle();
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    rst = 1'b0;

    // Fill every word with a known pattern (a*0x11)
    for (int a = 0; a < D; a += 2) begin
      set_wr(0, a, W'(a * 17), 8'hFF);
      set_wr(1, a + 1, W'((a + 1) * 17), 8'hFF);
      step();
    end
    idle();

    // R2: plain read on all ports
    for (int r = 0; r < NR; r++) set_rd(r, 1'b1, 3);
    step();
    idle();

    // R1: partial write to word 3 (0x33 -> 0x3A)
    set_wr(0, 3, 8'hAA, 8'h0F);
    step();
    idle();
    set_rd(2, 1'b1, 3);
    step();
    check("R1", 2, port_q(2), 8'h3A);
    idle();

    // R6: port 1 wins low nibble, port 0 keeps high nibble -> 0x12
    set_wr(0, 5, 8'h11, 8'hFF);
    set_wr(1, 5, 8'h22, 8'h0F);
    step();
    idle();
    set_rd(1, 1'b1, 5);
    step();
    check("R6", 1, port_q(1), 8'h12);
    idle();

    // R4 and R5: read word 7 (0x77) while port 0 writes high nibble 0x5
    set_wr(0, 7, 8'h5A, 8'hF0);
    set_rd(0, 1'b1, 7);
    set_rd(1, 1'b1, 7);
    step();
    check("R4", 0, port_q(0), 8'h57);
    check("R5", 1, port_q(1), 8'h77);
    idle();
    set_rd(1, 1'b1, 7);
    step();
    check("R1", 1, port_q(1), 8'h57);
    idle();

    // R3: enable low holds across a write to the same word
    set_wr(0, 7, 8'h00, 8'hFF);
    set_rd(0, 1'b0, 7);
    step();
    check("R3", 0, port_q(0), 8'h57);
    idle();

    // R7: asynchronous reset visible before any edge
    rd_arst[1] = 1'b1;
    #1;
    check("R7", 1, port_q(1), T_ARST[1*W +: W]);
    step();
    idle();

    // R8: gated synchronous reset on port 0
    rd_srst[0] = 1'b1;
    step();
    check("R8", 0, port_q(0), 8'h57);
    set_rd(0, 1'b1, 2);
    step();
    check("R8", 0, port_q(0), T_SRST[0 +: W]);
    idle();

    // R9: ungated synchronous reset on port 1
    rd_srst[1] = 1'b1;
    step();
    check("R9", 1, port_q(1), T_SRST[1*W +: W]);
    idle();

    // Random multi-port traffic over four words for frequent collisions
    for (int c = 0; c < 4000; c++) begin
      for (int j = 0; j < NW; j++) begin
        int sel;
        logic [W-1:0] be;
        sel = int'($urandom % 4);
        be  = (sel == 0) ? 8'h00 : (sel == 1) ? 8'hFF : W'($urandom);
        set_wr(j, int'($urandom % 4), W'($urandom), be);
      end
      for (int r = 0; r < NR; r++) begin
        set_rd(r, ($urandom % 4) != 0, int'($urandom % 4));
        rd_srst[r] = ($urandom % 16) == 0;
        rd_arst[r] = ($urandom % 32) == 0;
      end
      rst = ($urandom % 128) == 0;
      step();
    end
    idle();
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule